// File: doc/BRIEF.md
# Event-Triggered Single-Move Transfer Unit

This block lets an interrupt grant be served by one memory-to-memory data move instead of a software service routine. It keeps a small set of service channels. Each channel holds a source address, a destination address, an 8-bit remaining-move count and three mode bits: byte or word size, source step enable and destination step enable. The interrupt priority logic outside the block decides which request wins. When it grants one that is routed here, the block holds the processor, reads the source, writes the destination and advances that channel. No processor status is saved.

A channel whose count has already run down to zero does not move data. The grant is handed back as an ordinary interrupt request for that channel, so software sees the end of a block of moves through its normal service path. Channels are loaded through a one-cycle configuration write. Memory is reached through a simple request/acknowledge master port that may insert wait states.

Top module: `evt_xfer_unit`

## Requirements
- R1: After synchronous reset, `cpu_halt`, `xfer_done`, `irq_pass` and `mem_req` are low, and every channel count is zero, so the first grant to any channel is handed back as an interrupt.
- R2: A grant (`gnt_vld` high at a clock edge while idle) to a channel with a nonzero count raises `cpu_halt` in the next cycle. In that same cycle the block issues a read (`mem_req`=1, `mem_we`=0) at the channel's source address.
- R3: After the read is acknowledged, the block issues a write (`mem_we`=1) at the destination address carrying the data that was read. `mem_word`=0 selects byte size with the data in bits 7:0. `mem_word`=1 selects 16-bit word size, with the low byte at the address and the high byte at the address plus one.
- R4: `cpu_halt` stays high from the cycle after the grant through the update cycle, which is 3 cycles plus every wait cycle of the read and the write. It is low otherwise, and it is high whenever `mem_req` is high.
- R5: `xfer_done` pulses for exactly one cycle, the update cycle, with `done_ch` giving the channel served. `cpu_halt` drops in the cycle after.
- R6: In the update cycle the source address advances by 1 (byte) or 2 (word) when the source step bit is set, and it is left unchanged when the bit is clear. The destination address behaves the same way under its own step bit.
- R7: Each move decrements the channel count by one. A grant to a channel whose count is zero makes no memory access and does not raise `cpu_halt`. Instead `irq_pass` pulses for one cycle in the next cycle, with `irq_pass_ch` giving the channel.
- R8: Grants that arrive while a move is in progress are ignored and leave the granted channel's state unchanged.
- R9: Addresses advance modulo 2^ADDR_W.
- R10: A configuration write (`cfg_we`) loads all fields of the addressed channel only. If it coincides with that channel's update cycle, the written values win.
- R11: While a memory request waits for `mem_ack`, the request, its address and its direction stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the channel selected by cfg_ch |
| cfg_ch | input | CH_W | Channel to load |
| cfg_src | input | ADDR_W | Source address |
| cfg_dst | input | ADDR_W | Destination address |
| cfg_cnt | input | 8 | Number of moves before hand-back |
| cfg_word | input | 1 | 1 = word moves, 0 = byte moves |
| cfg_src_inc | input | 1 | Step the source address after each move |
| cfg_dst_inc | input | 1 | Step the destination address after each move |
| gnt_vld | input | 1 | Interrupt grant routed to this block |
| gnt_ch | input | CH_W | Channel of the grant |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| cpu_halt | output | 1 | Hold normal program execution |
| xfer_done | output | 1 | One-cycle pulse when a move completes |
| done_ch | output | CH_W | Channel of the completed move |
| irq_pass | output | 1 | One-cycle pulse: grant handed back as an interrupt |
| irq_pass_ch | output | CH_W | Channel handed back |

## Verification
The bench builds the unit with NUM_CH=4 and ADDR_W=8. With those values the bench's memory model covers the whole address space, so the address wrap from 0xFE back to 0x00 can be reached, and every channel can be reused and reprogrammed within a short run. The memory model's wait states make read and write stretch by known amounts. This lets the halt window be measured exactly and lets a grant land while a move is still under way.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;

    localparam int CNT_W  = 8;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_UPDATE = 2'd3
    } xfer_state_t;

    typedef struct packed {
        logic word;
        logic src_inc;
        logic dst_inc;
    } chan_mode_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [1:0] addr_step(input logic word);
        return word ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/evt_chan_bank.sv
module evt_chan_bank
    import evt_xfer_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  chan_mode_t        cfg_mode,
    input  logic              upd_en,
    input  logic [CH_W-1:0]   act_ch,
    input  logic [CH_W-1:0]   gnt_ch,
    output logic              gnt_cnt_zero,
    output logic [ADDR_W-1:0] act_src,
    output logic [ADDR_W-1:0] act_dst,
    output chan_mode_t        act_mode
);

    logic [ADDR_W-1:0] src_r  [NUM_CH];
    logic [ADDR_W-1:0] dst_r  [NUM_CH];
    logic [CNT_W-1:0]  cnt_r  [NUM_CH];
    chan_mode_t        mode_r [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [ADDR_W-1:0] step;
        assign step = ADDR_W'(addr_step(mode_r[i].word));

        always_ff @(posedge clk) begin
            if (rst) begin
                src_r[i]  <= '0;
                dst_r[i]  <= '0;
                cnt_r[i]  <= '0;
                mode_r[i] <= '0;
            end else if (cfg_we && cfg_ch == CH_W'(i)) begin
                src_r[i]  <= cfg_src;
                dst_r[i]  <= cfg_dst;
                cnt_r[i]  <= cfg_cnt;
                mode_r[i] <= cfg_mode;
            end else if (upd_en && act_ch == CH_W'(i)) begin
                if (mode_r[i].src_inc) src_r[i] <= src_r[i] + step;
                if (mode_r[i].dst_inc) dst_r[i] <= dst_r[i] + step;
                if (cnt_r[i] != '0)    cnt_r[i] <= cnt_r[i] - 1'b1;
            end
        end
    end

    always_comb begin
        gnt_cnt_zero = 1'b1;
        act_src      = '0;
        act_dst      = '0;
        act_mode     = '0;
        if (int'(gnt_ch) < NUM_CH) gnt_cnt_zero = (cnt_r[gnt_ch] == '0);
        if (int'(act_ch) < NUM_CH) begin
            act_src  = src_r[act_ch];
            act_dst  = dst_r[act_ch];
            act_mode = mode_r[act_ch];
        end
    end

endmodule

// File: rtl/evt_xfer_fsm.sv
module evt_xfer_fsm
    import evt_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gnt_vld,
    input  logic [CH_W-1:0]   gnt_ch,
    input  logic              gnt_cnt_zero,
    input  logic [ADDR_W-1:0] act_src,
    input  logic [ADDR_W-1:0] act_dst,
    input  chan_mode_t        act_mode,
    output logic [CH_W-1:0]   act_ch,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              cpu_halt,
    output logic              upd_en,
    output logic              irq_pass,
    output logic [CH_W-1:0]   irq_pass_ch
);

    xfer_state_t       state;
    logic [WORD_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            act_ch      <= '0;
            data_q      <= '0;
            irq_pass    <= 1'b0;
            irq_pass_ch <= '0;
        end else begin
            irq_pass <= 1'b0;
            unique case (state)
                ST_IDLE: if (gnt_vld) begin
                    if (gnt_cnt_zero) begin
                        irq_pass    <= 1'b1;
                        irq_pass_ch <= gnt_ch;
                    end else begin
                        act_ch <= gnt_ch;
                        state  <= ST_READ;
                    end
                end
                ST_READ: if (mem_ack) begin
                    data_q <= act_mode.word ? mem_rdata
                                            : {{(WORD_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
                    state  <= ST_WRITE;
                end
                ST_WRITE: if (mem_ack) state <= ST_UPDATE;
                ST_UPDATE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_word  = act_mode.word;
        mem_addr  = (state == ST_WRITE) ? act_dst : act_src;
        mem_wdata = data_q;
        cpu_halt  = (state != ST_IDLE);
        upd_en    = (state == ST_UPDATE);
    end

endmodule

// File: rtl/evt_xfer_unit.sv
module evt_xfer_unit
    import evt_xfer_pkg::*;
#(
    parameter  int NUM_CH = 16,
    parameter  int ADDR_W = 16,
    localparam int CH_W   = idx_w(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [7:0]        cfg_cnt,
    input  logic              cfg_word,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    input  logic              gnt_vld,
    input  logic [CH_W-1:0]   gnt_ch,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              cpu_halt,
    output logic              xfer_done,
    output logic [CH_W-1:0]   done_ch,
    output logic              irq_pass,
    output logic [CH_W-1:0]   irq_pass_ch
);

    chan_mode_t        cfg_mode;
    chan_mode_t        act_mode;
    logic [CH_W-1:0]   act_ch;
    logic [ADDR_W-1:0] act_src;
    logic [ADDR_W-1:0] act_dst;
    logic              gnt_cnt_zero;
    logic              upd_en;

    assign cfg_mode = '{word: cfg_word, src_inc: cfg_src_inc, dst_inc: cfg_dst_inc};

    evt_chan_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) bank_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_ch       (cfg_ch),
        .cfg_src      (cfg_src),
        .cfg_dst      (cfg_dst),
        .cfg_cnt      (cfg_cnt),
        .cfg_mode     (cfg_mode),
        .upd_en       (upd_en),
        .act_ch       (act_ch),
        .gnt_ch       (gnt_ch),
        .gnt_cnt_zero (gnt_cnt_zero),
        .act_src      (act_src),
        .act_dst      (act_dst),
        .act_mode     (act_mode)
    );

    evt_xfer_fsm #(.ADDR_W(ADDR_W), .CH_W(CH_W)) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .gnt_vld      (gnt_vld),
        .gnt_ch       (gnt_ch),
        .gnt_cnt_zero (gnt_cnt_zero),
        .act_src      (act_src),
        .act_dst      (act_dst),
        .act_mode     (act_mode),
        .act_ch       (act_ch),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_word     (mem_word),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .cpu_halt     (cpu_halt),
        .upd_en       (upd_en),
        .irq_pass     (irq_pass),
        .irq_pass_ch  (irq_pass_ch)
    );

    assign xfer_done = upd_en;
    assign done_ch   = act_ch;

endmodule

// File: rtl/evt_xfer_chk.sv
module evt_xfer_chk #(
    parameter int ADDR_W = 16,
    parameter int CH_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cpu_halt,
    input logic              xfer_done,
    input logic              irq_pass
);

    // R4
    halt_covers_access_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_halt);

    // R2
    halt_opens_with_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_halt) |-> (mem_req && !mem_we));

    // R3
    write_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack));

    // R5
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);

    // R5
    done_releases_halt_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (cpu_halt && !mem_req) ##1 !cpu_halt);

    // R7
    pass_without_move_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pass |-> (!cpu_halt && !mem_req));

    // R7
    pass_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pass |=> !irq_pass);

    // R11
    wait_holds_request_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind evt_xfer_unit evt_xfer_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .cpu_halt  (cpu_halt),
    .xfer_done (xfer_done),
    .irq_pass  (irq_pass)
);

// File: tb/evt_xfer_unit_tb_top.sv
module evt_xfer_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW  = 8;
    localparam int CW  = 2;

    typedef struct packed {
        logic [1:0] ch;
        logic [7:0] src;
        logic [7:0] dst;
        logic [7:0] cnt;
        logic       word;
        logic       sinc;
        logic       dinc;
        logic [1:0] ws;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h10, 8'h80, 8'd2, 1'b0, 1'b1, 1'b1, 2'd0},
        '{2'd1, 8'h20, 8'h90, 8'd2, 1'b1, 1'b1, 1'b1, 2'd1},
        '{2'd2, 8'h30, 8'hA0, 8'd3, 1'b0, 1'b1, 1'b0, 2'd0},
        '{2'd3, 8'h40, 8'hB0, 8'd2, 1'b1, 1'b0, 1'b1, 2'd2},
        '{2'd0, 8'h50, 8'hC0, 8'd1, 1'b1, 1'b0, 1'b0, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_ch = '0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [7:0]    cfg_cnt = '0;
    logic          cfg_word = 1'b0;
    logic          cfg_src_inc = 1'b0;
    logic          cfg_dst_inc = 1'b0;
    logic          gnt_vld = 1'b0;
    logic [CW-1:0] gnt_ch = '0;
    logic          mem_req, mem_we, mem_word, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata, mem_rdata;
    logic          cpu_halt, xfer_done, irq_pass;
    logic [CW-1:0] done_ch, irq_pass_ch;

    logic [7:0]    mem [256];
    logic          pl_we = 1'b0;
    logic [7:0]    pl_a = '0;
    logic [7:0]    pl_d = '0;
    int            ws = 0;
    int            wcnt = 0;
    int            wr_cnt = 0;
    int            total = 0;
    int            bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_xfer_unit #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_cnt(cfg_cnt), .cfg_word(cfg_word), .cfg_src_inc(cfg_src_inc),
        .cfg_dst_inc(cfg_dst_inc), .gnt_vld(gnt_vld), .gnt_ch(gnt_ch),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cpu_halt(cpu_halt), .xfer_done(xfer_done), .done_ch(done_ch),
        .irq_pass(irq_pass), .irq_pass_ch(irq_pass_ch)
    );

    // memory model: byte array, little-endian words, programmable wait states
    assign mem_ack   = mem_req && (wcnt >= ws);
    assign mem_rdata = {mem[8'(mem_addr + 8'd1)], mem[mem_addr]};

    always_ff @(posedge clk) begin
        if (mem_req && !mem_ack) wcnt <= wcnt + 1;
        else                     wcnt <= 0;
        if (pl_we) mem[pl_a] <= pl_d;
        else if (mem_req && mem_we && mem_ack) begin
            mem[mem_addr] <= mem_wdata[7:0];
            if (mem_word) mem[8'(mem_addr + 8'd1)] <= mem_wdata[15:8];
            wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a & 255) * 7 + 3);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic preload(input int a, input int d);
        pl_we = 1'b1; pl_a = 8'(a); pl_d = 8'(d);
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic program_ch(input int ch, input int s, input int d, input int c,
                              input bit w, input bit si, input bit di);
        cfg_we = 1'b1; cfg_ch = CW'(ch); cfg_src = AW'(s); cfg_dst = AW'(d);
        cfg_cnt = 8'(c); cfg_word = w; cfg_src_inc = si; cfg_dst_inc = di;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one grant; returns halt cycles, done pulses, done channel, pass flag/channel, writes
    task automatic run_grant(input int ch, input int w, output int hc, output int dn,
                             output int dch, output int ps, output int pch, output int wd);
        int w0;
        w0 = wr_cnt; ws = w;
        gnt_ch = CW'(ch); gnt_vld = 1'b1;
        @(negedge clk);
        gnt_vld = 1'b0;
        ps = int'(irq_pass); pch = int'(irq_pass_ch);
        hc = 0; dn = 0; dch = -1;
        while (cpu_halt && hc < 60) begin
            if (xfer_done) begin dn++; dch = int'(done_ch); end
            hc++;
            @(negedge clk);
        end
        @(negedge clk);
        wd = wr_cnt - w0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hc, dn, dch, ps, pch, wd;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 256; a++) preload(a, pat(a));
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state at the ports
        chk("R1", "cpu_halt", int'(cpu_halt), 0);
        chk("R1", "xfer_done", int'(xfer_done), 0);
        chk("R1", "irq_pass", int'(irq_pass), 0);
        chk("R1", "mem_req", int'(mem_req), 0);
        run_grant(2, 0, hc, dn, dch, ps, pch, wd);
        chk("R1", "count zero after reset gives pass", ps, 1);
        chk("R1", "no halt after reset grant", hc, 0);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            int st, s, d;
            t = VECS[v];
            st = t.word ? 2 : 1;
            for (int i = 0; i < 8; i++) preload(int'(t.dst) + i, 0);
            program_ch(int'(t.ch), int'(t.src), int'(t.dst), int'(t.cnt), t.word, t.sinc, t.dinc);
            for (int k = 0; k < int'(t.cnt); k++) begin
                s = (int'(t.src) + k * st * int'(t.sinc)) & 255;
                d = (int'(t.dst) + k * st * int'(t.dinc)) & 255;
                run_grant(int'(t.ch), int'(t.ws), hc, dn, dch, ps, pch, wd);
                chk("R2 R3 R6", "dest low byte", int'(mem[d]), int'(pat(s)));
                if (t.word) chk("R3 R6", "dest high byte", int'(mem[(d + 1) & 255]), int'(pat(s + 1)));
                chk("R4", "halt cycles", hc, 3 + 2 * int'(t.ws));
                chk("R5", "done pulses", dn, 1);
                chk("R5", "done channel", dch, int'(t.ch));
                chk("R7", "no pass on move", ps, 0);
            end
            run_grant(int'(t.ch), 0, hc, dn, dch, ps, pch, wd);
            chk("R7", "pass after count ran out", ps, 1);
            chk("R7", "pass channel", pch, int'(t.ch));
            chk("R7", "no halt on pass", hc, 0);
            chk("R7", "no write on pass", wd, 0);
        end

        // R3 byte move leaves the neighbour byte alone
        preload(8'hE0, 0); preload(8'hE1, 8'hEE);
        program_ch(1, 8'h15, 8'hE0, 1, 1'b0, 1'b0, 1'b0);
        run_grant(1, 1, hc, dn, dch, ps, pch, wd);
        chk("R3", "byte move value", int'(mem[8'hE0]), int'(pat(8'h15)));
        chk("R3", "byte move neighbour", int'(mem[8'hE1]), 8'hEE);

        // R9 source wraps from 0xFE to 0x00 in word mode
        for (int i = 0; i < 4; i++) preload(8'h60 + i, 0);
        program_ch(1, 8'hFE, 8'h60, 2, 1'b1, 1'b1, 1'b1);
        run_grant(1, 0, hc, dn, dch, ps, pch, wd);
        run_grant(1, 0, hc, dn, dch, ps, pch, wd);
        chk("R9", "wrapped source low", int'(mem[8'h62]), int'(pat(0)));
        chk("R9", "wrapped source high", int'(mem[8'h63]), int'(pat(1)));

        // R8 grant during a move is ignored; R10 channels independent
        preload(8'hD0, 0); preload(8'hD8, 0);
        program_ch(2, 8'h70, 8'hD0, 1, 1'b0, 1'b0, 1'b0);
        program_ch(3, 8'h71, 8'hD8, 1, 1'b0, 1'b0, 1'b0);
        ws = 3; gnt_ch = 2'd2; gnt_vld = 1'b1;
        @(negedge clk);
        gnt_ch = 2'd3;
        @(negedge clk);
        gnt_vld = 1'b0;
        dn = 0;
        for (int i = 0; i < 20; i++) begin
            if (xfer_done) dn++;
            @(negedge clk);
        end
        chk("R8", "one move for two grants", dn, 1);
        chk("R8", "busy grant wrote nothing", int'(mem[8'hD8]), 0);
        chk("R10", "channel 2 moved", int'(mem[8'hD0]), int'(pat(8'h70)));
        run_grant(3, 0, hc, dn, dch, ps, pch, wd);
        chk("R8", "ignored channel still moves", ps, 0);
        chk("R10", "channel 3 own data", int'(mem[8'hD8]), int'(pat(8'h71)));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule